// File: doc/BRIEF.md
# Power and Sleep Button Event Logic

This block conditions two active-low front-panel buttons, one for power and one for sleep, and turns their presses into sticky event status for power-management software. Each raw input is brought into the clock domain with a two-flop synchronizer. It is then filtered by a debouncer that counts millisecond ticks. The debounced power-button level is also driven out, so that an optional external power-management controller can track the button.

A debounced press sets two status bits for that button: a fixed-function bit and a general-purpose event bit. The fixed-function bit can be disabled per button. Any detection is held off until standby power has been good for a programmable number of ticks. The status bits are level-sticky: a write-one-to-clear strobe has no effect while the button is still held down. The block raises a wake request from the power button without condition, and from the sleep button only when software enables it. In legacy mode, a power-button press while main power is on raises a sleep-entry request that switches main power off. The same press resets the power-button status bits.

Top module: `button_event_ctrl`

## Requirements
- R1: Each button input passes through a two-flop synchronizer and then a debouncer. The debounced level changes only after the synchronized input has differed from it on DEB_TICKS consecutive tick cycles. The debounced power level goes low exactly DEB_TICKS+2 clock cycles after the raw input falls while ticks are present every cycle. A low pulse shorter than DEB_TICKS cycles never reaches `pwr_btn_no`.
- R2: Without `ms_tick_i`, the debouncer never accepts a new level.
- R3: A debounced low on a button, while detection is armed, sets that button's general-purpose status bit on the next clock edge.
- R4: A button's fixed-function status bit is set by a press only when that button's fixed-enable input is 1. When the input is 0, only the general-purpose bit sets.
- R5: A 1 on either clear strobe of a button clears both status bits of that button on the next edge. The other button's status is left unchanged.
- R6: While a button is still debounced low with detection armed, a clear strobe leaves its status bits set.
- R7: Detection stays disarmed until `sb_pwr_good_i` has been high for HOLDOFF_TICKS ticks. The status bit of a button already held down sets on the edge after that. Dropping `sb_pwr_good_i` disarms detection again.
- R8: `wake_req_o` is 1 when the power general-purpose status bit is set, or when the sleep general-purpose status bit is set and `slp_wake_en_i` is 1. It is 0 otherwise.
- R9: With `legacy_mode_i` and `main_pwr_on_i` both 1, an armed debounced power press drives `sleep_req_o` to 1 on the next edge and forces both power status bits to 0. With main power off, the press sets status normally and `sleep_req_o` stays 0.
- R10: After reset, all status bits, `wake_req_o` and `sleep_req_o` are 0 and `pwr_btn_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| pwr_btn_ni | input | 1 | Raw power button, active low |
| slp_btn_ni | input | 1 | Raw sleep button, active low |
| sb_pwr_good_i | input | 1 | Standby power good |
| main_pwr_on_i | input | 1 | Main power is on |
| pwr_fix_en_i | input | 1 | Allow the power fixed-function status bit to set |
| slp_fix_en_i | input | 1 | Allow the sleep fixed-function status bit to set |
| legacy_mode_i | input | 1 | Legacy power-button mode |
| slp_wake_en_i | input | 1 | Sleep-button wake enable |
| pwr_clr_fix_i | input | 1 | Write-one-to-clear, power fixed-function bit |
| pwr_clr_gpe_i | input | 1 | Write-one-to-clear, power general-purpose bit |
| slp_clr_fix_i | input | 1 | Write-one-to-clear, sleep fixed-function bit |
| slp_clr_gpe_i | input | 1 | Write-one-to-clear, sleep general-purpose bit |
| pwr_fix_sts_o | output | 1 | Power fixed-function status |
| pwr_gpe_sts_o | output | 1 | Power general-purpose status |
| slp_fix_sts_o | output | 1 | Sleep fixed-function status |
| slp_gpe_sts_o | output | 1 | Sleep general-purpose status |
| pwr_btn_no | output | 1 | Debounced power button, active low |
| wake_req_o | output | 1 | Wake request |
| sleep_req_o | output | 1 | Legacy sleep-entry (power off) request |

## Verification
The bench builds the block with DEB_TICKS=4 and HOLDOFF_TICKS=6, with a tick on every cycle. This makes the exact acceptance cycle and every pulse length around the debounce threshold cheap to check. It sweeps pulse widths from 1 to DEB_TICKS+2 and expects rejection below the threshold. A short holdoff puts the cycle on which a held button first sets status within a few cycles. The bench also covers all combinations of wake-enable and status that matter.

// File: rtl/btn_evt_pkg.sv
package btn_evt_pkg;
  localparam int NUM_BTN = 2;
  localparam int BTN_PWR = 0;
  localparam int BTN_SLP = 1;

  typedef struct packed {
    logic fix;
    logic gpe;
  } btn_sts_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RST_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = $clog2(DEB_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        lvl_q <= lvl_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/btn_holdoff.sv
module btn_holdoff #(
  parameter int HOLDOFF_TICKS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pwr_good_i,
  output logic armed_o
);
  localparam int HW = $clog2(HOLDOFF_TICKS + 1);
  localparam logic [HW-1:0] FULL = HW'(HOLDOFF_TICKS);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!pwr_good_i)            cnt_q <= '0;
    else if (tick_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == FULL);
endmodule

// File: rtl/btn_status.sv
module btn_status
  import btn_evt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     press_i,
  input  logic     fix_en_i,
  input  logic     clr_i,
  input  logic     kill_i,
  output btn_sts_t sts_o
);
  btn_sts_t sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
    end else if (kill_i) begin
      sts_q <= '0;
    end else begin
      // level-sticky: an active press wins over a clear
      if (press_i)      sts_q.gpe <= 1'b1;
      else if (clr_i)   sts_q.gpe <= 1'b0;
      if (press_i && fix_en_i) sts_q.fix <= 1'b1;
      else if (clr_i)          sts_q.fix <= 1'b0;
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/button_event_ctrl.sv
module button_event_ctrl
  import btn_evt_pkg::*;
#(
  parameter int DEB_TICKS     = 16,
  parameter int HOLDOFF_TICKS = 1000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ms_tick_i,
  input  logic pwr_btn_ni,
  input  logic slp_btn_ni,
  input  logic sb_pwr_good_i,
  input  logic main_pwr_on_i,
  input  logic pwr_fix_en_i,
  input  logic slp_fix_en_i,
  input  logic legacy_mode_i,
  input  logic slp_wake_en_i,
  input  logic pwr_clr_fix_i,
  input  logic pwr_clr_gpe_i,
  input  logic slp_clr_fix_i,
  input  logic slp_clr_gpe_i,
  output logic pwr_fix_sts_o,
  output logic pwr_gpe_sts_o,
  output logic slp_fix_sts_o,
  output logic slp_gpe_sts_o,
  output logic pwr_btn_no,
  output logic wake_req_o,
  output logic sleep_req_o
);
  logic [NUM_BTN-1:0] raw_n, sync_n, deb_n, press, fix_en, clr, kill;
  btn_sts_t           sts [NUM_BTN];
  logic               det_armed;
  logic               sleep_req_q;

  assign raw_n[BTN_PWR]  = pwr_btn_ni;
  assign raw_n[BTN_SLP]  = slp_btn_ni;
  assign fix_en[BTN_PWR] = pwr_fix_en_i;
  assign fix_en[BTN_SLP] = slp_fix_en_i;
  assign clr[BTN_PWR]    = pwr_clr_fix_i | pwr_clr_gpe_i;
  assign clr[BTN_SLP]    = slp_clr_fix_i | slp_clr_gpe_i;

  btn_holdoff #(.HOLDOFF_TICKS(HOLDOFF_TICKS)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (ms_tick_i),
    .pwr_good_i (sb_pwr_good_i),
    .armed_o    (det_armed)
  );

  // legacy power-off only applies to the power button
  assign kill[BTN_PWR] = legacy_mode_i & main_pwr_on_i & press[BTN_PWR];
  assign kill[BTN_SLP] = 1'b0;

  for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
    btn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_n[b]),
      .q_o    (sync_n[b])
    );

    btn_debounce #(.DEB_TICKS(DEB_TICKS)) u_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (ms_tick_i),
      .lvl_i  (sync_n[b]),
      .lvl_o  (deb_n[b])
    );

    assign press[b] = det_armed & ~deb_n[b];

    btn_status u_sts (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .press_i  (press[b]),
      .fix_en_i (fix_en[b]),
      .clr_i    (clr[b]),
      .kill_i   (kill[b]),
      .sts_o    (sts[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sleep_req_q <= 1'b0;
    else         sleep_req_q <= kill[BTN_PWR];
  end

  assign pwr_fix_sts_o = sts[BTN_PWR].fix;
  assign pwr_gpe_sts_o = sts[BTN_PWR].gpe;
  assign slp_fix_sts_o = sts[BTN_SLP].fix;
  assign slp_gpe_sts_o = sts[BTN_SLP].gpe;
  assign pwr_btn_no    = deb_n[BTN_PWR];
  assign wake_req_o    = sts[BTN_PWR].gpe | (sts[BTN_SLP].gpe & slp_wake_en_i);
  assign sleep_req_o   = sleep_req_q;
endmodule

// File: rtl/button_event_ctrl_chk.sv
module button_event_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ms_tick_i,
  input logic main_pwr_on_i,
  input logic pwr_fix_en_i,
  input logic legacy_mode_i,
  input logic pwr_clr_fix_i,
  input logic pwr_clr_gpe_i,
  input logic pwr_fix_sts_o,
  input logic pwr_gpe_sts_o,
  input logic pwr_btn_no,
  input logic sleep_req_o,
  input logic det_armed
);
  AST_DEB_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pwr_btn_no) |-> $past(ms_tick_i)); // R2

  AST_STICKY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_armed && !pwr_btn_no && !(legacy_mode_i && main_pwr_on_i)) |=> pwr_gpe_sts_o); // R6

  AST_FIX_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_fix_sts_o) |-> $past(pwr_fix_en_i)); // R4

  AST_CLR_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwr_clr_fix_i || pwr_clr_gpe_i) && !(det_armed && !pwr_btn_no))
      |=> (!pwr_gpe_sts_o && !pwr_fix_sts_o)); // R5

  AST_NO_SET_UNARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_armed && !pwr_gpe_sts_o) |=> !pwr_gpe_sts_o); // R7

  AST_LEGACY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_armed && !pwr_btn_no && legacy_mode_i && main_pwr_on_i)
      |=> (sleep_req_o && !pwr_gpe_sts_o && !pwr_fix_sts_o)); // R9
endmodule

bind button_event_ctrl button_event_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ms_tick_i     (ms_tick_i),
  .main_pwr_on_i (main_pwr_on_i),
  .pwr_fix_en_i  (pwr_fix_en_i),
  .legacy_mode_i (legacy_mode_i),
  .pwr_clr_fix_i (pwr_clr_fix_i),
  .pwr_clr_gpe_i (pwr_clr_gpe_i),
  .pwr_fix_sts_o (pwr_fix_sts_o),
  .pwr_gpe_sts_o (pwr_gpe_sts_o),
  .pwr_btn_no    (pwr_btn_no),
  .sleep_req_o   (sleep_req_o),
  .det_armed     (det_armed)
);

// File: tb/button_event_ctrl_tb_top.sv
module button_event_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int DEB   = 4;
  localparam int HOLD  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1;
  logic pwr_n = 1'b1, slp_n = 1'b1, sb_good = 1'b0, main_on = 1'b0;
  logic pwr_fe = 1'b1, slp_fe = 1'b1, legacy = 1'b0, wake_en = 1'b1;
  logic pcf = 1'b0, pcg = 1'b0, scf = 1'b0, scg = 1'b0;
  logic pfs, pgs, sfs, sgs, pbo, wake, slreq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  button_event_ctrl #(.DEB_TICKS(DEB), .HOLDOFF_TICKS(HOLD)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ms_tick_i(tick),
    .pwr_btn_ni(pwr_n), .slp_btn_ni(slp_n),
    .sb_pwr_good_i(sb_good), .main_pwr_on_i(main_on),
    .pwr_fix_en_i(pwr_fe), .slp_fix_en_i(slp_fe),
    .legacy_mode_i(legacy), .slp_wake_en_i(wake_en),
    .pwr_clr_fix_i(pcf), .pwr_clr_gpe_i(pcg),
    .slp_clr_fix_i(scf), .slp_clr_gpe_i(scg),
    .pwr_fix_sts_o(pfs), .pwr_gpe_sts_o(pgs),
    .slp_fix_sts_o(sfs), .slp_gpe_sts_o(sgs),
    .pwr_btn_no(pbo), .wake_req_o(wake), .sleep_req_o(slreq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic settle();
    cyc(DEB + 4);
  endtask

  task automatic clr_pwr();
    pcg = 1'b1; cyc(1); pcg = 1'b0;
  endtask

  task automatic clr_slp();
    scf = 1'b1; cyc(1); scf = 1'b0;
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R10 reset state
    chk("R10 pwr_fix", pfs, 1'b0); chk("R10 pwr_gpe", pgs, 1'b0);
    chk("R10 slp_fix", sfs, 1'b0); chk("R10 slp_gpe", sgs, 1'b0);
    chk("R10 btn_out", pbo, 1'b1); chk("R10 wake", wake, 1'b0);
    chk("R10 sleep_req", slreq, 1'b0);

    // R1 pulse-width sweep around the threshold
    for (int len = 1; len <= DEB + 2; len++) begin
      logic seen_low;
      seen_low = 1'b0;
      pwr_n = 1'b0;
      for (int k = 0; k < len; k++) begin
        cyc(1);
        if (!pbo) seen_low = 1'b1;
      end
      pwr_n = 1'b1;
      for (int k = 0; k < DEB + 4; k++) begin
        cyc(1);
        if (!pbo) seen_low = 1'b1;
      end
      chk($sformatf("R1 pulse len %0d", len), seen_low, logic'(len >= DEB));
      settle();
    end

    // R1 exact acceptance cycle
    pwr_n = 1'b0;
    cyc(DEB + 1);
    chk("R1 one cycle before accept", pbo, 1'b1);
    cyc(1);
    chk("R1 accept at DEB+2", pbo, 1'b0);
    pwr_n = 1'b1; settle();
    chk("R1 release accepted", pbo, 1'b1);

    // R2 no ticks, no acceptance
    tick = 1'b0;
    pwr_n = 1'b0;
    cyc(4 * DEB + 10);
    chk("R2 held without ticks", pbo, 1'b1);
    tick = 1'b1;
    settle();
    chk("R2 accepted once ticks resume", pbo, 1'b0);

    // R7 holdoff: button already held, standby comes up
    chk("R7 no status while disarmed", pgs, 1'b0);
    sb_good = 1'b1;
    cyc(HOLD);
    chk("R7 still disarmed at HOLD", pgs, 1'b0);
    cyc(1);
    chk("R7 set after HOLD ticks", pgs, 1'b1);
    chk("R4 fix set when enabled", pfs, 1'b1);
    chk("R8 wake from power", wake, 1'b1);

    // R6 clear while held
    clr_pwr();
    chk("R6 gpe stays while held", pgs, 1'b1);
    chk("R6 fix stays while held", pfs, 1'b1);
    pwr_n = 1'b1; settle();

    // R5 clear after release
    clr_pwr();
    chk("R5 pwr gpe cleared", pgs, 1'b0);
    chk("R5 pwr fix cleared", pfs, 1'b0);
    chk("R8 no wake", wake, 1'b0);

    // R4 fixed bit disabled
    pwr_fe = 1'b0;
    pwr_n = 1'b0; settle();
    chk("R4 gpe set with fix disabled", pgs, 1'b1);
    chk("R4 fix not set", pfs, 1'b0);
    pwr_n = 1'b1; settle();
    pwr_fe = 1'b1;
    pcf = 1'b1; cyc(1); pcf = 1'b0;
    chk("R5 fix strobe clears gpe", pgs, 1'b0);

    // sleep button and R8 wake combinations
    slp_n = 1'b0; settle();
    chk("R3 slp gpe set", sgs, 1'b1);
    chk("R4 slp fix set", sfs, 1'b1);
    chk("R8 slp wake enabled", wake, 1'b1);
    wake_en = 1'b0; cyc(1);
    chk("R8 slp wake disabled", wake, 1'b0);
    clr_slp();
    chk("R6 slp stays while held", sgs, 1'b1);
    slp_n = 1'b1; settle();
    pwr_n = 1'b0; settle(); pwr_n = 1'b1; settle();
    chk("R8 power wakes without enable", wake, 1'b1);
    clr_slp();
    chk("R5 slp gpe cleared", sgs, 1'b0);
    chk("R5 slp fix cleared", sfs, 1'b0);
    chk("R5 pwr untouched by slp clear", pgs, 1'b1);
    wake_en = 1'b1;

    // R9 legacy with main power on
    legacy = 1'b1; main_on = 1'b1;
    pwr_n = 1'b0;
    cyc(DEB + 2);
    chk("R9 no request before press seen", slreq, 1'b0);
    cyc(1);
    chk("R9 sleep request", slreq, 1'b1);
    chk("R9 pwr gpe reset", pgs, 1'b0);
    chk("R9 pwr fix reset", pfs, 1'b0);
    main_on = 1'b0;
    cyc(1);
    chk("R9 main off, status sets", pgs, 1'b1);
    cyc(1);
    chk("R9 main off, no request", slreq, 1'b0);
    pwr_n = 1'b1; settle();
    legacy = 1'b0; clr_pwr();

    // R7 rearm after standby drops
    sb_good = 1'b0; cyc(1);
    slp_n = 1'b0; settle();
    chk("R7 disarmed after standby drop", sgs, 1'b0);
    slp_n = 1'b1; settle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule